// File: doc/BRIEF.md
# Framed Synchronous Serial Block Streamer

This block is a transmit-only synchronous serial port. It reads a contiguous run of 32-bit words from a word-addressed memory, starting at a programmable start address and ending at a programmable end address, and shifts them out to an external logger on a serial data line. A serial clock and a one-period framing pulse go with the data. Each transfer is started by a single-cycle sync pulse on the system clock side.

The serial clock is divided down from the system clock. It has a fast and a slow rate, and the fast rate is twice the slow one. The clock can run all the time or be gated, so that it runs only around a transfer. The data can be framed as one field that covers the whole block, or as repeated 8-, 16- or 32-bit fields. The framing pulse comes one serial period before the first bit of each field, and its polarity can be set. Words are fetched with one-cycle read strobes, and the word comes back on the following system cycle. The handshake input from the logger side has no effect.

Top module: `ssi_streamer`

## Requirements
- R1: The serial clock has a 50% duty cycle. Its period is 2*DIV_HALF system cycles when `cfg_fast`=1 and 4*DIV_HALF system cycles when `cfg_fast`=0.
- R2: With `cfg_gate`=0 the serial clock runs all the time. With `cfg_gate`=1 it is held low while idle. It runs from the first serial rising edge after an accepted sync (period 1) up to and including the third period after the last data bit. It is low again from the fourth period after the last data bit.
- R3: `sdata_o` and the framing pulse change only together with a rising edge of the internal serial clock.
- R4: The block is sent most significant bit first, one bit per serial period, word by word from `cfg_start` up to and including `cfg_end`. Bit k of the block occupies period P0+1+k. `sdata_o` is 0 in every period that carries no data bit.
- R5: `cfg_fsize` selects the field size: 0 = the whole block is one field, 1 = 8-bit fields, 2 = 16-bit fields, 3 = 32-bit fields. The framing pulse is active for exactly the one period just before the first bit of each field. Words are always 32 bits.
- R6: The first framing pulse falls in period P0. P0 is 3 at the slow rate and 4 at the fast rate.
- R7: `sfr_o` equals the framing pulse XOR `cfg_fpol`, so its idle level equals `cfg_fpol`.
- R8: A sync pulse that arrives while a block is in progress is ignored. The current block completes unchanged and no second block follows.
- R9: If `cfg_end` < `cfg_start`, a sync causes no memory read and no data. With gating on, the serial clock stays low.
- R10: Each word of a block is read exactly once, through a `mem_rd_o` strobe one system cycle wide with the address on `mem_addr_o`. No strobe is issued while idle.
- R11: `rdy_i` has no effect on any output.
- R12: During and right after reset, `sclk_o` and `sdata_o` are 0, `mem_rd_o` is 0 and `sfr_o` equals `cfg_fpol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | One-cycle pulse that starts a block |
| rdy_i | input | 1 | Handshake from the logger; has no effect |
| cfg_fast | input | 1 | 1 selects the fast serial rate |
| cfg_gate | input | 1 | 1 gates the serial clock while idle |
| cfg_fsize | input | 2 | Field size code |
| cfg_fpol | input | 1 | Inverts the framing pulse |
| cfg_start | input | AW | First word address of the block |
| cfg_end | input | AW | Last word address of the block |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | AW | Memory word address |
| mem_data_i | input | 32 | Read word, valid the cycle after the strobe |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data |
| sfr_o | output | 1 | Framing pulse |

## Verification
On every cycle the assertions check four things. The data and framing outputs move only on serial rising edges. The read strobe is one cycle wide and occurs only during a transfer. The gated clock stays low whenever the port is idle. How these outputs line up with the serial periods can only be shown by the bench's scenarios, compared against a behavioural model cycle by cycle. That includes the period of the first framing pulse at each rate, the field boundaries for each size code, the tail length and the MSB-first bit order. The scenarios also show that a sync during a transfer is dropped, that an inverted address range produces nothing, and that the handshake input has no effect.

// File: rtl/ssi_pkg.sv
package ssi_pkg;

    localparam int WORD_W   = 32;
    localparam int BIDX_W   = $clog2(WORD_W);
    localparam int TAIL_LEN = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SEND,
        ST_TAIL
    } seq_state_e;

    typedef enum logic [1:0] {
        FS_BLOCK = 2'd0,
        FS_8     = 2'd1,
        FS_16    = 2'd2,
        FS_32    = 2'd3
    } field_size_e;

    // Serial period in which the first framing pulse is placed.
    function automatic logic [2:0] frame_period(input logic fast);
        return fast ? 3'd4 : 3'd3;
    endfunction

    // True when the bit with in-word index nb opens a new field.
    function automatic logic field_start(input field_size_e fs,
                                         input logic [BIDX_W-1:0] nb);
        case (fs)
            FS_8:    return nb[2:0] == 3'd0;
            FS_16:   return nb[3:0] == 4'd0;
            FS_32:   return nb == '0;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ssi_clkgen.sv
module ssi_clkgen #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic fast,
    output logic sclk_q,
    output logic rise
);
    localparam int CW = $clog2(2 * DIV_HALF + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] half;
    logic          tick;

    always_comb begin
        half = fast ? CW'(DIV_HALF) : CW'(2 * DIV_HALF);
        tick = (cnt >= half - 1'b1);
        rise = tick && !sclk_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            sclk_q <= 1'b0;
        end else if (tick) begin
            cnt    <= '0;
            sclk_q <= !sclk_q;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ssi_shifter.sv
module ssi_shifter #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [WORD_W-1:0] mem_data,
    input  logic              load,
    input  logic              adv,
    output logic              bit_out
);
    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] shreg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            shreg_q <= '0;
        end else begin
            if (capture) hold_q <= mem_data;
            if (load)
                shreg_q <= hold_q;
            else if (adv)
                shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
        end
    end

    assign bit_out = shreg_q[WORD_W-1];
endmodule

// File: rtl/ssi_seq.sv
module ssi_seq
    import ssi_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rise,
    input  logic          sync_i,
    input  logic          fast,
    input  field_size_e   fsize,
    input  logic [AW-1:0] start_addr,
    input  logic [AW-1:0] end_addr,
    output logic [AW-1:0] addr_q,
    output logic          rd_q,
    output logic          capture,
    output logic          load,
    output logic          win_q,
    output logic          pulse_q,
    output logic          busy
);
    seq_state_e        st_q;
    logic [2:0]        cnt_q;
    logic [BIDX_W-1:0] bidx_q;
    logic              pend_q;
    logic              rd_dly_q;
    logic              last_bit;

    assign busy     = (st_q != ST_IDLE);
    assign capture  = rd_dly_q;
    assign load     = rise && (st_q == ST_SEND) && (bidx_q == '0);
    assign last_bit = (bidx_q == BIDX_W'(WORD_W - 1)) && (addr_q == end_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            cnt_q    <= '0;
            bidx_q   <= '0;
            addr_q   <= '0;
            pend_q   <= 1'b0;
            win_q    <= 1'b0;
            pulse_q  <= 1'b0;
            rd_q     <= 1'b0;
            rd_dly_q <= 1'b0;
        end else begin
            rd_q     <= 1'b0;
            rd_dly_q <= rd_q;
            if (rise && st_q == ST_IDLE) pend_q <= 1'b0;
            if (sync_i && st_q == ST_IDLE) pend_q <= 1'b1;
            if (rise) begin
                case (st_q)
                    ST_IDLE: begin
                        pulse_q <= 1'b0;
                        if (pend_q && start_addr <= end_addr) begin
                            st_q  <= ST_LEAD;
                            cnt_q <= 3'd1;
                            win_q <= 1'b1;
                        end
                    end
                    ST_LEAD: begin
                        cnt_q <= cnt_q + 3'd1;
                        if (cnt_q + 3'd1 == frame_period(fast)) begin
                            pulse_q <= 1'b1;
                            rd_q    <= 1'b1;
                            addr_q  <= start_addr;
                            bidx_q  <= '0;
                            st_q    <= ST_SEND;
                        end
                    end
                    ST_SEND: begin
                        bidx_q  <= bidx_q + 1'b1;
                        pulse_q <= !last_bit && field_start(fsize, bidx_q + 1'b1);
                        if (bidx_q == BIDX_W'(WORD_W - 1)) begin
                            if (addr_q == end_addr) begin
                                st_q  <= ST_TAIL;
                                cnt_q <= '0;
                            end else begin
                                addr_q <= addr_q + 1'b1;
                                rd_q   <= 1'b1;
                            end
                        end
                    end
                    default: begin
                        pulse_q <= 1'b0;
                        if (cnt_q == 3'(TAIL_LEN)) begin
                            win_q <= 1'b0;
                            st_q  <= ST_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 3'd1;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/ssi_streamer.sv
module ssi_streamer
    import ssi_pkg::*;
#(
    parameter int AW       = 7,
    parameter int DIV_HALF = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sync_i,
    input  logic          rdy_i,
    input  logic          cfg_fast,
    input  logic          cfg_gate,
    input  logic [1:0]    cfg_fsize,
    input  logic          cfg_fpol,
    input  logic [AW-1:0] cfg_start,
    input  logic [AW-1:0] cfg_end,
    output logic          mem_rd_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic [31:0]   mem_data_i,
    output logic          sclk_o,
    output logic          sdata_o,
    output logic          sfr_o
);
    logic sclk_q;
    logic rise;
    logic capture;
    logic load;
    logic win_q;
    logic pulse_q;
    logic busy;
    logic rdy_unused;

    assign rdy_unused = rdy_i;

    ssi_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
        .clk    (clk),
        .rst    (rst),
        .fast   (cfg_fast),
        .sclk_q (sclk_q),
        .rise   (rise)
    );

    ssi_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .rise       (rise),
        .sync_i     (sync_i),
        .fast       (cfg_fast),
        .fsize      (field_size_e'(cfg_fsize)),
        .start_addr (cfg_start),
        .end_addr   (cfg_end),
        .addr_q     (mem_addr_o),
        .rd_q       (mem_rd_o),
        .capture    (capture),
        .load       (load),
        .win_q      (win_q),
        .pulse_q    (pulse_q),
        .busy       (busy)
    );

    ssi_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .mem_data (mem_data_i),
        .load     (load),
        .adv      (rise),
        .bit_out  (sdata_o)
    );

    assign sclk_o = sclk_q && (win_q || !cfg_gate);
    assign sfr_o  = pulse_q ^ cfg_fpol;
endmodule

// File: rtl/ssi_streamer_chk.sv
module ssi_streamer_chk (
    input logic clk,
    input logic rst,
    input logic cfg_gate,
    input logic cfg_fpol,
    input logic sclk_o,
    input logic sdata_o,
    input logic sfr_o,
    input logic mem_rd_o,
    input logic sclk_int,
    input logic busy
);
    // R10: strobe lasts a single system cycle
    p_strobe_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        mem_rd_o |=> !mem_rd_o);

    // R10: no strobe outside a transfer
    p_strobe_busy_r10: assert property (@(posedge clk) disable iff (rst)
        mem_rd_o |-> busy);

    // R3: data moves only with a serial rising edge
    p_data_edge_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdata_o) |-> $rose(sclk_int));

    // R3: framing output moves only with a serial rising edge (polarity held)
    p_frame_edge_r3: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sfr_o) && $stable(cfg_fpol)) |-> $rose(sclk_int));

    // R2: gated clock is quiet while idle
    p_gated_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_gate && !busy) |-> !sclk_o);
endmodule

bind ssi_streamer ssi_streamer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_gate (cfg_gate),
    .cfg_fpol (cfg_fpol),
    .sclk_o   (sclk_o),
    .sdata_o  (sdata_o),
    .sfr_o    (sfr_o),
    .mem_rd_o (mem_rd_o),
    .sclk_int (sclk_q),
    .busy     (busy)
);

// File: tb/tb_ssi_streamer.sv
module tb_ssi_streamer;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 7;
    localparam int DH = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sync_i = 1'b0;
    logic          rdy_i = 1'b0;
    logic          cfg_fast = 1'b0;
    logic          cfg_gate = 1'b1;
    logic [1:0]    cfg_fsize = 2'd0;
    logic          cfg_fpol = 1'b0;
    logic [AW-1:0] cfg_start = '0;
    logic [AW-1:0] cfg_end = '0;
    logic          mem_rd_o;
    logic [AW-1:0] mem_addr_o;
    logic [31:0]   mem_data_i = '0;
    logic          sclk_o;
    logic          sdata_o;
    logic          sfr_o;

    int checks = 0;
    int errors = 0;
    int rd_count = 0;
    bit done = 0;
    bit sclk_seen = 0;
    bit data_seen = 0;

    always #(CLK_PERIOD / 2) clk = !clk;

    ssi_streamer #(.AW(AW), .DIV_HALF(DH)) dut (
        .clk(clk), .rst(rst), .sync_i(sync_i), .rdy_i(rdy_i),
        .cfg_fast(cfg_fast), .cfg_gate(cfg_gate), .cfg_fsize(cfg_fsize),
        .cfg_fpol(cfg_fpol), .cfg_start(cfg_start), .cfg_end(cfg_end),
        .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i),
        .sclk_o(sclk_o), .sdata_o(sdata_o), .sfr_o(sfr_o)
    );

    function automatic logic [31:0] word_at(input int a);
        return (32'(a) + 32'd1) * 32'h9E3779B9 ^ 32'h5A5AC3C3;
    endfunction

    // memory: word returned on the cycle after the strobe
    always @(posedge clk) begin
        if (mem_rd_o) begin
            mem_data_i <= word_at(int'(mem_addr_o));
            rd_count++;
        end
    end

    // behavioural reference model
    int   m_div = 0;
    bit   m_ph = 0, m_win = 0, m_busy = 0, m_pend = 0;
    bit   m_sd = 0, m_pulse = 0;
    int   m_p = 0, m_p0 = 3, m_fw = 0;
    logic m_bits[$];

    always @(posedge clk) begin
        if (rst) begin
            m_div = 0; m_ph = 0; m_win = 0; m_busy = 0; m_pend = 0;
            m_sd = 0; m_pulse = 0; m_p = 0;
        end else begin
            bit was_busy;
            int half;
            was_busy = m_busy;
            half = cfg_fast ? DH : 2 * DH;
            if (m_div >= half - 1) begin
                m_div = 0;
                if (!m_ph) begin
                    if (!m_busy) begin
                        m_pulse = 0;
                        if (m_pend) begin
                            m_pend = 0;
                            if (cfg_start <= cfg_end) begin
                                m_busy = 1; m_win = 1; m_p = 1;
                                m_p0 = cfg_fast ? 4 : 3;
                                m_fw = (cfg_fsize == 0) ? 0 : (4 << cfg_fsize);
                                m_bits.delete();
                                for (int a = int'(cfg_start); a <= int'(cfg_end); a++)
                                    for (int b = 31; b >= 0; b--)
                                        m_bits.push_back(word_at(a)[b]);
                            end
                        end
                    end else begin
                        int k, nk, n;
                        m_p++;
                        n = m_bits.size();
                        k = m_p - m_p0 - 1;
                        nk = k + 1;
                        m_sd = (k >= 0 && k < n) ? m_bits[k] : 1'b0;
                        m_pulse = (nk >= 0 && nk < n) &&
                                  (nk == 0 || (m_fw != 0 && nk % m_fw == 0));
                        if (m_p == m_p0 + n + 4) begin
                            m_win = 0; m_busy = 0;
                        end
                    end
                end
                m_ph = !m_ph;
            end else begin
                m_div++;
            end
            if (sync_i && !was_busy) m_pend = 1;
        end
    end

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit exp_sclk;
            exp_sclk = m_ph && (m_win || !cfg_gate);
            if (sclk_o) sclk_seen = 1;
            if (sdata_o) data_seen = 1;
            checks++;
            if (sclk_o !== exp_sclk) begin
                errors++;
                $display("FAIL R1 R2 sclk_o t=%0t act=%b exp=%b", $time, sclk_o, exp_sclk);
            end
            checks++;
            if (sdata_o !== m_sd) begin
                errors++;
                $display("FAIL R4 sdata_o t=%0t act=%b exp=%b", $time, sdata_o, m_sd);
            end
            checks++;
            if (sfr_o !== (m_pulse ^ cfg_fpol)) begin
                errors++;
                $display("FAIL R5 R6 R7 sfr_o t=%0t act=%b exp=%b", $time, sfr_o,
                         m_pulse ^ cfg_fpol);
            end
        end
    end

    // R11: handshake input toggles throughout
    initial begin
        forever begin
            repeat (7) @(negedge clk);
            rdy_i = !rdy_i;
        end
    end

    task automatic check_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic run_block(input bit fast, input bit gate, input logic [1:0] fs,
                             input bit pol, input int s, input int e, input bit extra_sync);
        int nw, wait_cyc;
        nw = (e >= s) ? e - s + 1 : 0;
        @(negedge clk);
        cfg_fast = fast; cfg_gate = gate; cfg_fsize = fs; cfg_fpol = pol;
        cfg_start = AW'(s); cfg_end = AW'(e);
        repeat (20) @(negedge clk);
        rd_count = 0; sclk_seen = 0; data_seen = 0;
        sync_i = 1'b1;
        @(negedge clk);
        sync_i = 1'b0;
        wait_cyc = (nw * 32 + 12) * 4 * DH + 60;
        if (extra_sync) begin
            repeat (200) @(negedge clk);
            sync_i = 1'b1;          // R8: arrives mid-block
            @(negedge clk);
            sync_i = 1'b0;
            wait_cyc = wait_cyc - 201;
        end
        repeat (wait_cyc) @(negedge clk);
        check_int("R10 read strobes per block", rd_count, nw);
        if (nw == 0) begin
            check_int("R9 no data on empty range", int'(data_seen), 0);
            if (gate) check_int("R9 gated clock stays low", int'(sclk_seen), 0);
        end
        if (extra_sync) begin
            repeat (300) @(negedge clk);
            check_int("R8 no second block after ignored sync", rd_count, nw);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset values
        check_int("R12 sclk_o in reset", int'(sclk_o), 0);
        check_int("R12 sdata_o in reset", int'(sdata_o), 0);
        check_int("R12 mem_rd_o in reset", int'(mem_rd_o), 0);
        check_int("R12 sfr_o idle level", int'(sfr_o), int'(cfg_fpol));
        rst = 1'b0;
        @(negedge clk);
        check_int("R12 sdata_o after reset", int'(sdata_o), 0);
        check_int("R12 sclk_o after reset", int'(sclk_o), 0);

        run_block(1'b0, 1'b1, 2'd0, 1'b0, 2, 3, 1'b0);    // slow, whole-block field
        run_block(1'b1, 1'b1, 2'd1, 1'b1, 5, 5, 1'b0);    // fast, 8-bit fields, inverted
        run_block(1'b0, 1'b0, 2'd2, 1'b0, 0, 2, 1'b1);    // free clock, 16-bit, R8
        run_block(1'b1, 1'b1, 2'd3, 1'b0, 10, 11, 1'b0);  // fast, 32-bit fields
        run_block(1'b0, 1'b1, 2'd2, 1'b1, 9, 4, 1'b0);    // R9 inverted range
        run_block(1'b1, 1'b0, 2'd0, 1'b1, 127, 127, 1'b0); // top address, free clock

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule